// File: doc/BRIEF.md
# Byte Popcount Stable Sorter

This unit takes a 32-bit word and treats it as four byte lanes. It counts the set bits in each lane and uses that count as the lane's sort key. It then returns the same four bytes rearranged by key, in either ascending or descending order. The lowest bit of a second operand picks the direction.

The sort is stable. Lanes with equal keys keep the order they had in the input word, with the top byte counted as first. The unit is purely combinational: the result follows the operands within the same cycle. It is meant to sit in the execute stage of a datapath. The surrounding logic supplies the two operands and writes back the result.

The design has no state and no clock. The sort works through a rank network: each lane counts how many other lanes must come before it, and that count is the result slot it goes to.

Top module: `byte_popsort`

## Requirements
- R1: The input word is split into lanes at bits 31:24 (lane 0), 23:16 (lane 1), 15:8 (lane 2) and 7:0 (lane 3). Result slot 0 is bits 31:24 and slot 3 is bits 7:0.
- R2: A lane's key is the number of 1 bits in that byte, from 0 to 8.
- R3: When bit 0 of `mode_word` is 1, result bytes run in non-decreasing key order from slot 0 to slot 3, so the smallest key lands in bits 31:24.
- R4: When bit 0 of `mode_word` is 0, result bytes run in non-increasing key order from slot 0 to slot 3, so the largest key lands in bits 31:24.
- R5: Lanes with equal keys appear in the result in their input lane order, with the lower lane index in the lower slot index.
- R6: The result is a permutation of the four input bytes. Every byte is moved intact.
- R7: Bits 31:1 of `mode_word` have no effect on the result.
- R8: When all four keys are equal, the result equals the input word in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | 32 | Word whose bytes are sorted |
| mode_word | input | 32 | Direction operand; bit 0 = 1 ascending, 0 descending |
| word_out | output | 32 | Reassembled word with its bytes sorted |

## Verification
Every result is due in the same cycle as its stimulus, zero clock edges later, because no register lies between the operands and `word_out`. The bench applies each operand pair just after a falling clock edge and reads `word_out` 2 ns later, well before the next rising edge. This leaves the result settled and keeps the sample away from any edge. Expected words come from a bench model that sweeps key values in the chosen direction and collects matching lanes in input order. That is a different method from the design's rank network.

// File: rtl/bps_pkg.sv
package bps_pkg;
    localparam int unsigned BPS_LANES  = 4;
    localparam int unsigned BPS_LANE_W = 8;
    localparam int unsigned BPS_CTRL_W = 32;

    typedef enum logic {
        DIR_DESC = 1'b0,
        DIR_ASC  = 1'b1
    } bps_dir_e;
endpackage

// File: rtl/bps_lane_weight.sv
module bps_lane_weight #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned KEY_W  = $clog2(LANE_W + 1)
) (
    input  logic [LANE_W-1:0] lane,
    output logic [KEY_W-1:0]  weight
);
    always_comb begin
        weight = '0;
        for (int b = 0; b < int'(LANE_W); b++) begin
            weight = weight + KEY_W'(lane[b]);
        end
    end
endmodule

// File: rtl/bps_rank.sv
module bps_rank #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned KEY_W  = 4,
    parameter int unsigned RANK_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*KEY_W-1:0]  keys,
    input  bps_pkg::bps_dir_e       dir,
    output logic [LANES*RANK_W-1:0] ranks
);
    // Each lane's slot is the number of lanes that must precede it.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [RANK_W-1:0] cnt;
        always_comb begin
            logic [KEY_W-1:0] ki;
            logic [KEY_W-1:0] kj;
            logic             ahead;
            ki  = keys[i*KEY_W +: KEY_W];
            cnt = '0;
            for (int j = 0; j < int'(LANES); j++) begin
                kj    = keys[j*KEY_W +: KEY_W];
                ahead = 1'b0;
                if (j != i) begin
                    unique case (dir)
                        bps_pkg::DIR_ASC:  ahead = (kj < ki);
                        bps_pkg::DIR_DESC: ahead = (kj > ki);
                        default:           ahead = 1'b0;
                    endcase
                    if (kj == ki && j < i) ahead = 1'b1;
                end
                if (ahead) cnt = cnt + RANK_W'(1);
            end
        end
        assign ranks[i*RANK_W +: RANK_W] = cnt;
    end
endmodule

// File: rtl/bps_place.sv
module bps_place #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned RANK_W = 2
) (
    input  logic [LANES*LANE_W-1:0] lanes,
    input  logic [LANES*RANK_W-1:0] ranks,
    output logic [LANES*LANE_W-1:0] word_out
);
    localparam int unsigned TOP = LANES - 1;

    for (genvar p = 0; p < LANES; p++) begin : g_slot
        logic [LANE_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int i = 0; i < int'(LANES); i++) begin
                if (ranks[i*RANK_W +: RANK_W] == RANK_W'(p)) begin
                    pick = pick | lanes[i*LANE_W +: LANE_W];
                end
            end
        end
        assign word_out[(TOP-p)*LANE_W +: LANE_W] = pick;
    end
endmodule

// File: rtl/byte_popsort.sv
module byte_popsort #(
    parameter int unsigned LANES  = bps_pkg::BPS_LANES,
    parameter int unsigned LANE_W = bps_pkg::BPS_LANE_W,
    parameter int unsigned CTRL_W = bps_pkg::BPS_CTRL_W
) (
    input  logic [LANES*LANE_W-1:0] word_in,
    input  logic [CTRL_W-1:0]       mode_word,
    output logic [LANES*LANE_W-1:0] word_out
);
    localparam int unsigned KEY_W  = $clog2(LANE_W + 1);
    localparam int unsigned RANK_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned TOP    = LANES - 1;

    logic [LANES*LANE_W-1:0] lanes;
    logic [LANES*KEY_W-1:0]  keys;
    logic [LANES*RANK_W-1:0] ranks;
    bps_pkg::bps_dir_e       dir;
    logic                    mode_unused;

    assign dir         = bps_pkg::bps_dir_e'(mode_word[0]);
    assign mode_unused = ^mode_word[CTRL_W-1:1];

    // Lane 0 is the most significant byte.
    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign lanes[k*LANE_W +: LANE_W] = word_in[(TOP-k)*LANE_W +: LANE_W];
        bps_lane_weight #(.LANE_W(LANE_W), .KEY_W(KEY_W)) u_weight (
            .lane   (lanes[k*LANE_W +: LANE_W]),
            .weight (keys[k*KEY_W +: KEY_W])
        );
    end

    bps_rank #(.LANES(LANES), .KEY_W(KEY_W), .RANK_W(RANK_W)) u_rank (
        .keys  (keys),
        .dir   (dir),
        .ranks (ranks)
    );

    bps_place #(.LANES(LANES), .LANE_W(LANE_W), .RANK_W(RANK_W)) u_place (
        .lanes    (lanes),
        .ranks    (ranks),
        .word_out (word_out)
    );
endmodule

// File: rtl/bps_checker.sv
module bps_checker (
    input logic [31:0] word_in,
    input logic [31:0] mode_word,
    input logic [31:0] word_out
);
    int unsigned ko0, ko1, ko2, ko3, ki0, ki1, ki2, ki3;
    always_comb begin
        ko0 = $countones(word_out[31:24]);
        ko1 = $countones(word_out[23:16]);
        ko2 = $countones(word_out[15:8]);
        ko3 = $countones(word_out[7:0]);
        ki0 = $countones(word_in[31:24]);
        ki1 = $countones(word_in[23:16]);
        ki2 = $countones(word_in[15:8]);
        ki3 = $countones(word_in[7:0]);
    end

    always_comb begin
        // R3
        asc_order_chk: assert (!mode_word[0] || (ko0 <= ko1 && ko1 <= ko2 && ko2 <= ko3));
        // R4
        desc_order_chk: assert (mode_word[0] || (ko0 >= ko1 && ko1 >= ko2 && ko2 >= ko3));
        // R6
        byte_keep_chk: assert ((word_out[31:24] ^ word_out[23:16] ^ word_out[15:8] ^ word_out[7:0]) ==
                               (word_in[31:24] ^ word_in[23:16] ^ word_in[15:8] ^ word_in[7:0]));
        // R6
        ones_keep_chk: assert ($countones(word_out) == $countones(word_in));
        // R8
        equal_keys_chk: assert (!(ki0 == ki1 && ki1 == ki2 && ki2 == ki3) || word_out == word_in);
    end
endmodule

bind byte_popsort bps_checker u_bps_checker (
    .word_in   (word_in),
    .mode_word (mode_word),
    .word_out  (word_out)
);

// File: tb/test_byte_popsort.sv
module test_byte_popsort;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] word_in = '0;
    logic [31:0] mode_word = '0;
    logic [31:0] word_out;
    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    byte_popsort i_byte_popsort (
        .word_in   (word_in),
        .mode_word (mode_word),
        .word_out  (word_out)
    );

    // {word_in, mode_word, expected}
    localparam logic [95:0] VEC [10] = '{
        {32'h010307FF, 32'h00000001, 32'h010307FF}, // R3 distinct keys
        {32'h010307FF, 32'h00000000, 32'hFF070301}, // R4 distinct keys
        {32'hFF000FF0, 32'h00000001, 32'h000FF0FF}, // R5 tie in ascending
        {32'hFF000FF0, 32'h00000000, 32'hFF0FF000}, // R5 tie in descending
        {32'h80010300, 32'h00000001, 32'h00800103}, // R5 tie, ascending
        {32'h80010300, 32'h00000000, 32'h03800100}, // R5 tie, descending
        {32'h010307FF, 32'hFFFFFFFE, 32'hFF070301}, // R7 upper bits set, even
        {32'h010307FF, 32'h80000003, 32'h010307FF}, // R7 upper bits set, odd
        {32'h12488124, 32'h00000001, 32'h12488124}, // R8 all keys 2
        {32'h12488124, 32'h00000000, 32'h12488124}  // R8 all keys 2
    };

    function automatic logic [31:0] model(input logic [31:0] din, input logic [31:0] ctl);
        logic [31:0] res = '0;
        int pos = 0;
        for (int step = 0; step <= 8; step++) begin
            int v = ctl[0] ? step : 8 - step;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b = din[31-8*k -: 8];
                if ($countones(b) == v) begin
                    res[31-8*pos -: 8] = b;
                    pos++;
                end
            end
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] d, input logic [31:0] c);
        @(negedge clk);
        word_in = d;
        mode_word = c;
        #2;
    endtask

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        logic [31:0] d;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset zero word", word_out, 32'h0);
        rst = 1'b0;

        for (int v = 0; v < 10; v++) begin
            apply(VEC[v][95:64], VEC[v][63:32]);
            check($sformatf("R3/R4/R5/R7/R8 vector %0d", v), word_out, VEC[v][31:0]);
        end

        // R2: single lane with key 8, others 0 -> FF at one end
        apply(32'h0000FF00, 32'h1);
        check("R2 key 8 ascending", word_out, 32'h000000FF);
        apply(32'h0000FF00, 32'h0);
        check("R2 key 8 descending", word_out, 32'hFF000000);
        // R1: lane positions, already-descending input unchanged
        apply(32'hFF7F3F1F, 32'h0);
        check("R1 lanes in place", word_out, 32'hFF7F3F1F);
        apply(32'hFF7F3F1F, 32'h1);
        check("R1 lanes reversed", word_out, 32'h1F3F7FFF);
        // R7: same operand, every upper pattern
        apply(32'h0F010300, 32'h5555_5554);
        check("R7 even upper noise", word_out, model(32'h0F010300, 32'h0));
        apply(32'h0F010300, 32'hAAAA_AAAB);
        check("R7 odd upper noise", word_out, model(32'h0F010300, 32'h1));

        // R6: pseudo-random sweep against model
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            c = lfsr;
            apply(d, c);
            check("R6 random permutation", word_out, model(d, c));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule